// File: doc/BRIEF.md
# Decoded-Mask Issue Scoreboard

This block decides, for the instruction at the issue point, whether it may leave this cycle and where each of its source operands must be read from. The block does not compare encoded register numbers pair by pair. Every issued destination register number is turned into a 31-bit one-hot mask. That mask is pushed into a shift register that moves one level each time the execution pipeline advances. Integer and floating-point registers have their own mask shift registers.

The young levels of a shift register, whose results are not yet produced, are ORed into one dirty mask. A source or destination operand is in conflict when the AND of its own decoded mask with that dirty mask is non-zero. Each conflict counts only when the instruction is valid and actually uses that operand. All counted conflicts are ORed into one stall output.

The older levels can forward their results. For each source operand, the block reports the youngest level that holds a matching writer, or reports that the register file is to be used. A stalled instruction is held inside the block and checked again on every later cycle until it issues. While a stall lasts, an empty entry enters the head of the shift register. A flush empties both shift registers and drops the held instruction.

Top module: `issue_scoreboard`

## Requirements
- R1: Register numbers 0 to 30 decode to a one-hot mask with bit n set for register n. Register 31 decodes to an all-zero mask, so it never causes a stall and never gets a bypass select other than 0.
- R2: An issued writer's mask appears at level 0 on the next cycle. It moves up one level on each cycle with `adv_i` high, holds its level on cycles with `adv_i` low, and leaves after level DEPTH-1.
- R3: `stall_o` is 1 when the checked instruction reads a used source, or writes a destination, whose register matches a writer in levels 0 to STALL_LV-1 of the same register file.
- R4: A conflict counts only when the checked instruction is valid and the operand is in use (`in_use_a_i`, `in_use_b_i`, `in_wr_i`). An instruction with `in_wr_i` low pushes no mask.
- R5: `byp_a_o` and `byp_b_o` are 0 to select the register file. A value of L+1 selects pipeline level L, for the youngest matching writer in levels STALL_LV to DEPTH-1. The select is 0 when the operand is not in use or the instruction is not valid.
- R6: `in_fp_i`=1 selects the floating-point file and 0 selects the integer file. Writers in one file never cause a stall or a bypass for operands of the other file.
- R7: When the checked instruction is valid and does not issue, it is held. On the following cycles the held instruction is checked and the port inputs are ignored, until it issues.
- R8: `issue_o` is valid AND `adv_i` AND NOT `stall_o` AND NOT `flush_i`.
- R9: `flush_i` empties both mask shift registers and drops the held instruction in one cycle. No writer enters on a flush cycle.
- R10: On a stall cycle with `adv_i` high, level 0 receives an empty entry and the older entries advance.
- R11: After reset, both shift registers are empty, and with no valid input `stall_o`, `issue_o` and both bypass selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty the pipeline masks and drop the held instruction |
| adv_i | input | 1 | Execution pipeline advances this cycle |
| in_vld_i | input | 1 | New instruction present |
| in_fp_i | input | 1 | Operand file select: 1 floating point, 0 integer |
| in_use_a_i | input | 1 | Source A is read |
| in_src_a_i | input | 5 | Source A register number |
| in_use_b_i | input | 1 | Source B is read |
| in_src_b_i | input | 5 | Source B register number |
| in_wr_i | input | 1 | Destination is written |
| in_dst_i | input | 5 | Destination register number |
| stall_o | output | 1 | Hazard against a young writer |
| issue_o | output | 1 | Checked instruction leaves this cycle |
| byp_a_o | output | $clog2(DEPTH+1) | Source A forward select (0 = register file) |
| byp_b_o | output | $clog2(DEPTH+1) | Source B forward select (0 = register file) |

## Verification
The bench stalls a reader behind a fresh writer and changes the port inputs during the stall. A design that checked the live inputs instead of the held instruction would issue the wrong instruction early. It places two writers of one register in the forwarding levels at the same time. A priority encoder with the wrong order would select the older writer. Register 31, operands that are not in use, and writers in the other file must all stay silent; a missing zero-register rule or a missing qualification would show up as a false stall. Frozen advance, a flush while an instruction is held, and the boundary level DEPTH-1 check that entries neither leak nor move at the wrong time.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int REGW     = 5;
    localparam int MW       = 31;
    localparam int NOPS     = 3;
    localparam int NFILES   = 2;
    localparam int OP_A     = 0;
    localparam int OP_B     = 1;
    localparam int OP_D     = 2;
    localparam logic [REGW-1:0] ZERO_REG = 5'd31;

    typedef logic [MW-1:0] rmask_t;

    typedef enum logic {
        FILE_INT = 1'b0,
        FILE_FP  = 1'b1
    } rfile_e;

    typedef struct packed {
        logic            vld;
        rfile_e          file;
        logic            use_a;
        logic [REGW-1:0] src_a;
        logic            use_b;
        logic [REGW-1:0] src_b;
        logic            wr;
        logic [REGW-1:0] dst;
    } instr_t;

    function automatic rmask_t dec_reg(input logic [REGW-1:0] r);
        rmask_t m;
        m = '0;
        for (int i = 0; i < MW; i++) begin
            if (r == REGW'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sb_decode.sv
module sb_decode
    import sb_pkg::*;
(
    input  logic [NOPS-1:0][REGW-1:0] regs_i,
    output rmask_t [NOPS-1:0]         mask_o
);
    for (genvar k = 0; k < NOPS; k++) begin : g_op
        assign mask_o[k] = dec_reg(regs_i[k]);
    end
endmodule

// File: rtl/sb_mask_pipe.sv
module sb_mask_pipe
    import sb_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_i,
    input  logic                 adv_i,
    input  rmask_t               push_i,
    output rmask_t [DEPTH-1:0]   lv_o
);
    rmask_t [DEPTH-1:0] lv_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            lv_q <= '0;
        end else if (adv_i) begin
            lv_q[0] <= push_i;
            for (int k = 1; k < DEPTH; k++) begin
                lv_q[k] <= lv_q[k-1];
            end
        end
    end

    assign lv_o = lv_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_chk
        a_r1_level_onehot: assert property (@(posedge clk) disable iff (rst)
            $onehot0(lv_q[k]));
    end
    for (genvar k = 1; k < DEPTH; k++) begin : g_shift_chk
        a_r2_level_moves: assert property (@(posedge clk) disable iff (rst)
            (adv_i && !flush_i) |=> (lv_q[k] == $past(lv_q[k-1])));
    end

    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !flush_i) |=> $stable(lv_q));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (lv_q == '0));
endmodule

// File: rtl/sb_dirty.sv
module sb_dirty
    import sb_pkg::*;
#(
    parameter int NLV = 2
) (
    input  rmask_t [NLV-1:0] lv_i,
    output rmask_t           dirty_o
);
    rmask_t [NLV:0] acc;

    assign acc[0] = '0;
    for (genvar k = 0; k < NLV; k++) begin : g_or
        assign acc[k+1] = acc[k] | lv_i[k];
    end
    assign dirty_o = acc[NLV];
endmodule

// File: rtl/sb_conflict.sv
module sb_conflict
    import sb_pkg::*;
#(
    parameter  int DEPTH    = 6,
    parameter  int STALL_LV = 2,
    localparam int NBYP     = DEPTH - STALL_LV,
    localparam int SELW     = $clog2(DEPTH + 1)
) (
    input  logic              qual_i,
    input  rmask_t            opm_i,
    input  rmask_t            dirty_i,
    input  rmask_t [NBYP-1:0] byp_lv_i,
    output logic              hit_o,
    output logic [SELW-1:0]   sel_o
);
    logic [NBYP-1:0] lv_match;

    for (genvar k = 0; k < NBYP; k++) begin : g_match
        assign lv_match[k] = |(opm_i & byp_lv_i[k]);
    end

    assign hit_o = qual_i && (|(opm_i & dirty_i));

    always_comb begin
        sel_o = '0;
        for (int k = NBYP - 1; k >= 0; k--) begin
            if (qual_i && lv_match[k]) sel_o = SELW'(STALL_LV + k + 1);
        end
    end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
    import sb_pkg::*;
#(
    parameter  int DEPTH    = 6,
    parameter  int STALL_LV = 2,
    localparam int SELW     = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush_i,
    input  logic            adv_i,
    input  logic            in_vld_i,
    input  logic            in_fp_i,
    input  logic            in_use_a_i,
    input  logic [4:0]      in_src_a_i,
    input  logic            in_use_b_i,
    input  logic [4:0]      in_src_b_i,
    input  logic            in_wr_i,
    input  logic [4:0]      in_dst_i,
    output logic            stall_o,
    output logic            issue_o,
    output logic [SELW-1:0] byp_a_o,
    output logic [SELW-1:0] byp_b_o
);
    localparam int NBYP = DEPTH - STALL_LV;
    localparam int NSRC = 2;

    instr_t in_ins, cur, held_q;
    logic   held_vld_q;
    logic   issue;

    always_comb begin
        in_ins.vld   = in_vld_i;
        in_ins.file  = in_fp_i ? FILE_FP : FILE_INT;
        in_ins.use_a = in_use_a_i;
        in_ins.src_a = in_src_a_i;
        in_ins.use_b = in_use_b_i;
        in_ins.src_b = in_src_b_i;
        in_ins.wr    = in_wr_i;
        in_ins.dst   = in_dst_i;
    end

    assign cur = held_vld_q ? held_q : in_ins;

    // held instruction register
    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            held_vld_q <= 1'b0;
            held_q     <= '0;
        end else begin
            held_vld_q <= cur.vld && !issue;
            held_q     <= cur;
        end
    end

    // operand decode
    logic [NOPS-1:0][REGW-1:0] op_regs;
    rmask_t [NOPS-1:0]         opm;

    assign op_regs[OP_A] = cur.src_a;
    assign op_regs[OP_B] = cur.src_b;
    assign op_regs[OP_D] = cur.dst;

    sb_decode u_dec (
        .regs_i (op_regs),
        .mask_o (opm)
    );

    // per-file mask pipelines and dirty masks
    rmask_t [DEPTH-1:0] lv    [NFILES];
    rmask_t             dirty [NFILES];
    rmask_t             push  [NFILES];

    for (genvar f = 0; f < NFILES; f++) begin : g_file
        assign push[f] = (issue && cur.wr && (cur.file == rfile_e'(f))) ? opm[OP_D] : '0;

        sb_mask_pipe #(.DEPTH(DEPTH)) u_pipe (
            .clk     (clk),
            .rst     (rst),
            .flush_i (flush_i),
            .adv_i   (adv_i),
            .push_i  (push[f]),
            .lv_o    (lv[f])
        );

        sb_dirty #(.NLV(STALL_LV)) u_dirty (
            .lv_i    (lv[f][STALL_LV-1:0]),
            .dirty_o (dirty[f])
        );
    end

    rmask_t [DEPTH-1:0] lv_cur;
    rmask_t             dirty_cur;

    assign lv_cur    = (cur.file == FILE_FP) ? lv[1] : lv[0];
    assign dirty_cur = (cur.file == FILE_FP) ? dirty[1] : dirty[0];

    // source operand conflict and forwarding
    logic [NSRC-1:0]           src_qual;
    logic [NSRC-1:0]           src_hit;
    logic [NSRC-1:0][SELW-1:0] src_sel;

    assign src_qual[OP_A] = cur.vld && cur.use_a;
    assign src_qual[OP_B] = cur.vld && cur.use_b;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        sb_conflict #(.DEPTH(DEPTH), .STALL_LV(STALL_LV)) u_cf (
            .qual_i   (src_qual[s]),
            .opm_i    (opm[s]),
            .dirty_i  (dirty_cur),
            .byp_lv_i (lv_cur[DEPTH-1:STALL_LV]),
            .hit_o    (src_hit[s]),
            .sel_o    (src_sel[s])
        );
    end

    // destination ordering check
    logic dst_hit;
    assign dst_hit = cur.vld && cur.wr && (|(opm[OP_D] & dirty_cur));

    assign stall_o = (|src_hit) || dst_hit;
    assign issue   = cur.vld && adv_i && !stall_o && !flush_i;
    assign issue_o = issue;
    assign byp_a_o = src_sel[OP_A];
    assign byp_b_o = src_sel[OP_B];

    a_r8_stall_blocks_issue: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> !issue_o);

    a_r3_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> cur.vld);

    a_r7_held_kept: assert property (@(posedge clk) disable iff (rst)
        (cur.vld && !issue_o && !flush_i) |=> held_vld_q);

    a_r10_head_bubble: assert property (@(posedge clk) disable iff (rst)
        (stall_o && adv_i && !flush_i) |=> (lv[0][0] == '0 && lv[1][0] == '0));

    a_r5_sel_range_a: assert property (@(posedge clk) disable iff (rst)
        (byp_a_o != '0) |-> (int'(byp_a_o) > STALL_LV && int'(byp_a_o) <= DEPTH));

    a_r5_sel_range_b: assert property (@(posedge clk) disable iff (rst)
        (byp_b_o != '0) |-> (int'(byp_b_o) > STALL_LV && int'(byp_b_o) <= DEPTH));

    a_r1_zero_reg_quiet: assert property (@(posedge clk) disable iff (rst)
        (cur.src_a == ZERO_REG) |-> (byp_a_o == '0 && !src_hit[OP_A]));
endmodule

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb_top;
    localparam int DEPTH = 6;
    localparam int SL    = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush_i = 1'b0, adv_i = 1'b1;
    logic in_vld_i = 1'b0, in_fp_i = 1'b0, in_use_a_i = 1'b0, in_use_b_i = 1'b0, in_wr_i = 1'b0;
    logic [4:0] in_src_a_i = '0, in_src_b_i = '0, in_dst_i = '0;
    logic stall_o, issue_o;
    logic [2:0] byp_a_o, byp_b_o;

    always #10 clk = ~clk;

    issue_scoreboard #(.DEPTH(DEPTH), .STALL_LV(SL)) dut_i (
        .clk(clk), .rst(rst), .flush_i(flush_i), .adv_i(adv_i),
        .in_vld_i(in_vld_i), .in_fp_i(in_fp_i),
        .in_use_a_i(in_use_a_i), .in_src_a_i(in_src_a_i),
        .in_use_b_i(in_use_b_i), .in_src_b_i(in_src_b_i),
        .in_wr_i(in_wr_i), .in_dst_i(in_dst_i),
        .stall_o(stall_o), .issue_o(issue_o), .byp_a_o(byp_a_o), .byp_b_o(byp_b_o)
    );

    typedef struct {
        string tag;
        int    stall;
        int    issue;
        int    ba;
        int    bb;
    } exp_t;

    exp_t exq[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: encoded register numbers per level
    bit         mv [2][DEPTH];
    logic [4:0] mr [2][DEPTH];
    bit         hv = 1'b0;
    bit         h_vld, h_fp, h_ua, h_ub, h_wr;
    logic [4:0] h_a, h_b, h_d;

    function automatic int find(int f, logic [4:0] r, int lo, int hi);
        if (r == 5'd31) return -1;
        for (int l = lo; l < hi; l++) begin
            if (mv[f][l] && mr[f][l] == r) return l;
        end
        return -1;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // monitor: pop expected items and compare mid-cycle
    always @(negedge clk) begin
        exp_t e;
        if (exq.size() != 0) begin
            e = exq.pop_front();
            chk(e.tag, "stall_o", int'(stall_o), e.stall);
            chk(e.tag, "issue_o", int'(issue_o), e.issue);
            chk(e.tag, "byp_a_o", int'(byp_a_o), e.ba);
            chk(e.tag, "byp_b_o", int'(byp_b_o), e.bb);
        end
    end

    // driver: one cycle of stimulus plus the expected outputs
    task automatic cyc(bit vld, bit fp, bit ua, logic [4:0] a, bit ub, logic [4:0] b,
                       bit wr, logic [4:0] d, bit adv, bit fl, string tag);
        bit c_vld, c_fp, c_ua, c_ub, c_wr, st, iss;
        logic [4:0] c_a, c_b, c_d;
        int la, lb;
        exp_t e;
        in_vld_i = vld; in_fp_i = fp; in_use_a_i = ua; in_src_a_i = a;
        in_use_b_i = ub; in_src_b_i = b; in_wr_i = wr; in_dst_i = d;
        adv_i = adv; flush_i = fl;
        if (hv) begin
            c_vld = h_vld; c_fp = h_fp; c_ua = h_ua; c_a = h_a;
            c_ub = h_ub; c_b = h_b; c_wr = h_wr; c_d = h_d;
        end else begin
            c_vld = vld; c_fp = fp; c_ua = ua; c_a = a;
            c_ub = ub; c_b = b; c_wr = wr; c_d = d;
        end
        st = c_vld && ((c_ua && find(int'(c_fp), c_a, 0, SL) >= 0) ||
                       (c_ub && find(int'(c_fp), c_b, 0, SL) >= 0) ||
                       (c_wr && find(int'(c_fp), c_d, 0, SL) >= 0));
        iss = c_vld && adv && !st && !fl;
        la = find(int'(c_fp), c_a, SL, DEPTH);
        lb = find(int'(c_fp), c_b, SL, DEPTH);
        e.tag   = tag;
        e.stall = int'(st);
        e.issue = int'(iss);
        e.ba    = (c_vld && c_ua && la >= 0) ? la + 1 : 0;
        e.bb    = (c_vld && c_ub && lb >= 0) ? lb + 1 : 0;
        exq.push_back(e);
        @(posedge clk);
        if (fl) begin
            for (int f = 0; f < 2; f++)
                for (int l = 0; l < DEPTH; l++) mv[f][l] = 1'b0;
            hv = 1'b0;
        end else begin
            if (adv) begin
                for (int f = 0; f < 2; f++) begin
                    for (int l = DEPTH - 1; l > 0; l--) begin
                        mv[f][l] = mv[f][l-1];
                        mr[f][l] = mr[f][l-1];
                    end
                    mv[f][0] = iss && c_wr && (int'(c_fp) == f) && (c_d != 5'd31);
                    mr[f][0] = c_d;
                end
            end
            hv = c_vld && !iss;
            h_vld = c_vld; h_fp = c_fp; h_ua = c_ua; h_a = c_a;
            h_ub = c_ub; h_b = c_b; h_wr = c_wr; h_d = c_d;
        end
        #1;
    endtask

    task automatic wr_op(logic [4:0] d, bit fp, string tag);
        cyc(1, fp, 0, 5'd0, 0, 5'd0, 1, d, 1, 0, tag);
    endtask

    task automatic rd_op(logic [4:0] a, logic [4:0] b, bit fp, string tag);
        cyc(1, fp, 1, a, 1, b, 0, 5'd0, 1, 0, tag);
    endtask

    task automatic idle(string tag);
        cyc(0, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0, 1, 0, tag);
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 1; i++) idle("R2");
    endtask

    initial begin
        for (int f = 0; f < 2; f++)
            for (int l = 0; l < DEPTH; l++) begin mv[f][l] = 1'b0; mr[f][l] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R11 reset state
        idle("R11");
        idle("R11");

        // R3 stall, R7 hold, R5 forward, R10 bubble
        wr_op(5'd5, 0, "R2");
        rd_op(5'd5, 5'd31, 0, "R3");
        rd_op(5'd7, 5'd8, 0, "R7");
        rd_op(5'd7, 5'd8, 0, "R5");
        rd_op(5'd7, 5'd8, 0, "R7");
        idle("R10");
        drain();

        // R6 separate files
        wr_op(5'd5, 1, "R6");
        rd_op(5'd5, 5'd5, 0, "R6");
        rd_op(5'd5, 5'd1, 1, "R6");
        drain();

        // R1 zero register
        wr_op(5'd31, 0, "R1");
        rd_op(5'd31, 5'd31, 0, "R1");
        idle("R1");
        rd_op(5'd31, 5'd31, 0, "R1");
        wr_op(5'd31, 0, "R1");
        drain();

        // R4 qualification
        wr_op(5'd8, 0, "R4");
        cyc(1, 0, 0, 5'd8, 0, 5'd8, 0, 5'd0, 1, 0, "R4");
        cyc(0, 0, 1, 5'd8, 1, 5'd8, 1, 5'd8, 1, 0, "R4");
        cyc(1, 0, 0, 5'd0, 0, 5'd0, 0, 5'd9, 1, 0, "R4");
        rd_op(5'd9, 5'd9, 0, "R4");
        drain();

        // R5 youngest of two writers, then oldest level
        wr_op(5'd3, 0, "R5");
        wr_op(5'd3, 0, "R3");
        for (int i = 0; i < 4; i++) idle("R5");
        rd_op(5'd3, 5'd3, 0, "R5");
        rd_op(5'd2, 5'd3, 0, "R5");
        drain();
        wr_op(5'd12, 0, "R5");
        for (int i = 0; i < 5; i++) idle("R5");
        rd_op(5'd12, 5'd0, 0, "R5");
        rd_op(5'd12, 5'd0, 0, "R2");
        drain();

        // R2 frozen advance
        wr_op(5'd9, 0, "R2");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0, 0, 0, "R2");
        rd_op(5'd9, 5'd0, 0, "R2");
        drain();

        // R8 no issue without advance
        cyc(1, 0, 1, 5'd20, 0, 5'd0, 0, 5'd0, 0, 0, "R8");
        cyc(1, 0, 1, 5'd21, 0, 5'd0, 0, 5'd0, 1, 0, "R8");
        drain();

        // R9 flush
        wr_op(5'd4, 0, "R9");
        cyc(0, 0, 0, 5'd0, 0, 5'd0, 0, 5'd0, 1, 1, "R9");
        rd_op(5'd4, 5'd4, 0, "R9");
        wr_op(5'd6, 0, "R9");
        rd_op(5'd6, 5'd0, 0, "R9");
        cyc(1, 0, 1, 5'd6, 0, 5'd0, 1, 5'd6, 1, 1, "R9");
        idle("R9");
        cyc(1, 0, 1, 5'd6, 1, 5'd6, 1, 5'd6, 1, 1, "R9");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule